// File: doc/BRIEF.md
# SAR ADC Track and Convert Sequencer

This block sequences the sampling switch and the bit-step timing of a successive-approximation converter. It runs entirely on the converter's fast clock. A one-cycle convert-start request moves it out of idle. Depending on the selected tracking policy, it either converts at once or first opens a timed sampling window. It then runs a fixed-length conversion that is paced by a divided step strobe. It ends with a one-cycle done pulse.

The tracking policy also decides what the sampling switch does while the block is idle. It stays closed (tracking) in pre-tracking, reserved and dual-tracking modes. It stays open (input high-impedance) in post-tracking mode. The tracking-time and divide fields are captured at the accepted start and stay fixed until the block returns to idle. The comparator, DAC, input multiplexer and clock source lie outside this block.

Top module: `adc_track_seq`

## Requirements
- R1: In every cycle after reset the block is in exactly one of three situations. It is either tracking (`track_o`=1, `conv_o`=0), converting (`conv_o`=1, `track_o`=0), or idle (`busy_o`=0). The outputs `track_o` and `conv_o` are never high together, and `busy_o`=1 with `conv_o`=0 implies `track_o`=1.
- R2: With `mode_i`=2'b10 (pre-tracking) or 2'b00 (reserved, same behaviour), an accepted start makes `conv_o` and `busy_o` high from the very next cycle. No tracking window comes first.
- R3: With `mode_i`=2'b01 (post-tracking) or 2'b11 (dual-tracking), an accepted start opens a tracking window from the next cycle. During the window `track_o`=1, `busy_o`=1 and `conv_o`=0. The window lasts `trk_time_i`+2 cycles, and conversion begins in the cycle right after it.
- R4: A conversion keeps `conv_o` high for exactly 2 + 13*(`sar_div_i`+1) cycles.
- R5: Within a conversion, `step_o` pulses for one cycle exactly 13 times. The first conversion cycle is numbered 0. A pulse occurs in conversion cycle c when c = 1 + k*(`sar_div_i`+1) + `sar_div_i`, for k = 0 to 12.
- R6: `done_o` is high for exactly one cycle, which is the last conversion cycle. In the following cycle `busy_o`=0.
- R7: In idle with `mode_i`=2'b01, `track_o`=0. After a post-tracking conversion the switch therefore stays open until the next start.
- R8: In idle with `mode_i`=2'b11, `track_o`=1. After a dual-tracking conversion, tracking therefore resumes at once.
- R9: In idle with `mode_i`=2'b10 or 2'b00, `track_o`=1.
- R10: A `start_i` pulse in any cycle where `busy_o`=1 has no effect. This includes the cycle where `done_o`=1.
- R11: Changes of `mode_i`, `trk_time_i` or `sar_div_i` while busy do not alter the window length, the conversion length or the step positions.
- R12: While `rst` is high, and in the cycle after it falls, `busy_o`, `conv_o`, `step_o` and `done_o` are 0. `track_o` follows the idle rule of R7 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter fast clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Convert-start request, one cycle |
| mode_i | input | 2 | Tracking policy: 01 post, 10 pre, 11 dual, 00 as pre |
| trk_time_i | input | TRK_W | Tracking-window extension in cycles |
| sar_div_i | input | DIV_W | Step period minus one, in cycles |
| track_o | output | 1 | Sampling switch closed |
| conv_o | output | 1 | Conversion in progress |
| step_o | output | 1 | One-cycle strobe per SAR bit decision |
| busy_o | output | 1 | Timed window or conversion in progress |
| done_o | output | 1 | One-cycle pulse in the final conversion cycle |

## Verification
The hardest case to reach is a start request, or a field change, that arrives in exactly the wrong cycle. That means the cycle where `done_o` is high, or the middle of a step period once the divide field is already latched. A sloppy design would restart, or stretch the current step, in those cycles. The bench covers this by running many operations with random start pulses and random field values on every busy cycle. It always fires a start in the done cycle of those runs. It then compares every output in every cycle against a waveform worked out from the captured values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_RSVD = 2'b00,
        MODE_POST = 2'b01,
        MODE_PRE  = 2'b10,
        MODE_DUAL = 2'b11
    } trk_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WINDOW,
        PH_HEAD,
        PH_STEP,
        PH_TAIL
    } seq_phase_e;

    typedef struct packed {
        logic track;
        logic conv;
        logic step;
        logic busy;
        logic done;
    } seq_out_t;

    // Modes that open a timed sampling window after the start request
    function automatic logic has_window(trk_mode_e m);
        return (m == MODE_POST) || (m == MODE_DUAL);
    endfunction

    // Whether the sampling switch is closed while nothing is running
    function automatic logic idle_tracks(trk_mode_e m);
        return m != MODE_POST;
    endfunction

    function automatic logic is_conv_phase(seq_phase_e p);
        return (p == PH_HEAD) || (p == PH_STEP) || (p == PH_TAIL);
    endfunction

endpackage

// File: rtl/trk_window_timer.sv
module trk_window_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    input  logic             run,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expired_o = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sar_step_gen.sv
module sar_step_gen #(
    parameter int DIV_W = 5,
    parameter int STEPS = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             step_o,
    output logic             last_o
);
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

    logic [DIV_W-1:0] dcnt_q;
    logic [IDX_W-1:0] idx_q;

    assign step_o = run && (dcnt_q == '0);
    assign last_o = step_o && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt_q <= '0;
            idx_q  <= '0;
        end else if (clr) begin
            dcnt_q <= div;
            idx_q  <= '0;
        end else if (run) begin
            if (dcnt_q == '0) begin
                dcnt_q <= div;
                idx_q  <= idx_q + 1'b1;
            end else begin
                dcnt_q <= dcnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_track_seq.sv
module adc_track_seq
    import adc_seq_pkg::*;
#(
    parameter int TRK_W = 4,
    parameter int DIV_W = 5,
    parameter int STEPS = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [TRK_W-1:0] trk_time_i,
    input  logic [DIV_W-1:0] sar_div_i,
    output logic             track_o,
    output logic             conv_o,
    output logic             step_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int WIN_W = TRK_W + 1;

    seq_phase_e       ph_q, ph_d;
    trk_mode_e        mode_live;
    logic             accept;
    logic             win_done;
    logic             step_s, last_step;
    logic [DIV_W-1:0] div_q;
    logic [WIN_W-1:0] win_load;
    seq_out_t         out_s;

    assign mode_live = trk_mode_e'(mode_i);
    assign accept    = start_i && (ph_q == PH_IDLE);
    // Window of trk_time+2 cycles: counter runs from trk_time+1 down to 0
    assign win_load  = {1'b0, trk_time_i} + WIN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (accept) begin
            div_q <= sar_div_i;
        end
    end

    trk_window_timer #(.CNT_W(WIN_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && has_window(mode_live)),
        .value     (win_load),
        .run       (ph_q == PH_WINDOW),
        .expired_o (win_done)
    );

    sar_step_gen #(.DIV_W(DIV_W), .STEPS(STEPS)) u_step (
        .clk    (clk),
        .rst    (rst),
        .clr    (ph_q == PH_HEAD),
        .run    (ph_q == PH_STEP),
        .div    (div_q),
        .step_o (step_s),
        .last_o (last_step)
    );

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (accept) ph_d = has_window(mode_live) ? PH_WINDOW : PH_HEAD;
            PH_WINDOW: if (win_done) ph_d = PH_HEAD;
            PH_HEAD:   ph_d = PH_STEP;
            PH_STEP:   if (last_step) ph_d = PH_TAIL;
            PH_TAIL:   ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    always_comb begin
        out_s.track = (ph_q == PH_WINDOW) || ((ph_q == PH_IDLE) && idle_tracks(mode_live));
        out_s.conv  = is_conv_phase(ph_q);
        out_s.step  = step_s;
        out_s.busy  = (ph_q != PH_IDLE);
        out_s.done  = (ph_q == PH_TAIL);
    end

    assign track_o = out_s.track;
    assign conv_o  = out_s.conv;
    assign step_o  = out_s.step;
    assign busy_o  = out_s.busy;
    assign done_o  = out_s.done;
endmodule

// File: rtl/adc_track_seq_chk.sv
module adc_track_seq_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic track_o,
    input logic conv_o,
    input logic step_o,
    input logic busy_o,
    input logic done_o
);
    // R1
    track_conv_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(track_o && conv_o));

    // R1
    busy_window_track_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !conv_o) |-> track_o);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (conv_o && busy_o));

    // R6
    done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R5
    step_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (conv_o && $onehot0({step_o, done_o})));

    // R10
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    // R4
    conv_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_o && !done_o) |=> conv_o);
endmodule

bind adc_track_seq adc_track_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .track_o (track_o),
    .conv_o  (conv_o),
    .step_o  (step_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/adc_track_seq_bench.sv
`timescale 1ns/1ps
module adc_track_seq_bench;
    localparam int TRK_W = 4;
    localparam int DIV_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [1:0]       mode_i = 2'b01;
    logic [TRK_W-1:0] trk_time_i = '0;
    logic [DIV_W-1:0] sar_div_i = '0;
    logic track_o, conv_o, step_o, busy_o, done_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_track_seq #(.TRK_W(TRK_W), .DIV_W(DIV_W)) u_adc_track_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .trk_time_i(trk_time_i), .sar_div_i(sar_div_i),
        .track_o(track_o), .conv_o(conv_o), .step_o(step_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic has_win(logic [1:0] m);
        return (m == 2'b01) || (m == 2'b11);
    endfunction

    // Expected {track, conv, step, busy, done} in cycle i after the accepted start
    function automatic logic [4:0] expect_at(int i, logic [1:0] m, int t, int d);
        int w, l, c;
        logic stp;
        w = has_win(m) ? t + 2 : 0;
        l = 2 + 13 * (d + 1);
        if (i <= w) return 5'b10010;
        if (i <= w + l) begin
            c = i - w - 1;
            stp = (c >= 1) && (c <= l - 2) && (((c - 1) % (d + 1)) == d);
            return {1'b0, 1'b1, stp, 1'b1, (c == l - 1)};
        end
        return {(m != 2'b01), 4'b0000};
    endfunction

    task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got track/conv/step/busy/done=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic run_op(logic [1:0] m, int t, int d, bit pert);
        int w, l, nsteps;
        bit overlap;
        string tag;
        logic [4:0] got, exp;
        w = has_win(m) ? t + 2 : 0;
        l = 2 + 13 * (d + 1);
        nsteps = 0;
        overlap = 1'b0;
        @(negedge clk);
        start_i = 1'b1; mode_i = m; trk_time_i = TRK_W'(t); sar_div_i = DIV_W'(d);
        for (int i = 1; i <= w + l + 2; i++) begin
            @(negedge clk);
            got = {track_o, conv_o, step_o, busy_o, done_o};
            exp = expect_at(i, m, t, d);
            if (track_o && conv_o) overlap = 1'b1;
            if (step_o) nsteps++;
            if (i <= w) tag = pert ? "R3 R11 window" : "R3 window";
            else if (i <= w + l) begin
                if (got[2] !== exp[2]) tag = "R5 step";
                else if (got[0] !== exp[0]) tag = "R6 done";
                else if (i == w + 1 && w == 0) tag = "R2 immediate conversion";
                else tag = pert ? "R4 R10 R11 conversion" : "R4 conversion";
            end else if (m == 2'b01) tag = "R7 post idle";
            else if (m == 2'b11) tag = "R8 dual idle";
            else tag = "R9 pre idle";
            check(tag, got, exp);
            if (i < w + l) begin
                if (pert) begin
                    start_i = ($urandom % 3) == 0;
                    mode_i = 2'($urandom);
                    trk_time_i = TRK_W'($urandom);
                    sar_div_i = DIV_W'($urandom);
                end else begin
                    start_i = 1'b0;
                end
            end else begin
                // start in the done cycle must be ignored (R10)
                start_i = (i == w + l) ? pert : 1'b0;
                mode_i = m; trk_time_i = TRK_W'(t); sar_div_i = DIV_W'(d);
            end
        end
        start_i = 1'b0;
        check("R5 step count", 5'(nsteps), 5'd13);
        check("R1 track/conv exclusive", {4'b0, overlap}, 5'b0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        mode_i = 2'b01;
        repeat (3) @(negedge clk);
        check("R12 reset post", {track_o, conv_o, step_o, busy_o, done_o}, 5'b00000);
        mode_i = 2'b11;
        @(negedge clk);
        check("R12 R8 reset dual", {track_o, conv_o, step_o, busy_o, done_o}, 5'b10000);
        mode_i = 2'b10;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 R9 after reset pre", {track_o, conv_o, step_o, busy_o, done_o}, 5'b10000);
        mode_i = 2'b00;
        @(negedge clk);
        check("R9 idle reserved mode", {track_o, conv_o, step_o, busy_o, done_o}, 5'b10000);

        run_op(2'b10, 3, 0, 1'b0);
        run_op(2'b00, 0, 2, 1'b0);
        run_op(2'b01, 0, 0, 1'b0);
        run_op(2'b01, 15, 31, 1'b0);
        run_op(2'b11, 15, 1, 1'b1);
        run_op(2'b11, 0, 3, 1'b0);
        run_op(2'b10, 7, 31, 1'b1);
        for (int n = 0; n < 40; n++) begin
            run_op(2'($urandom), int'($urandom % 16), int'($urandom % 8), ($urandom % 2) == 1);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R10 watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule